// File: doc/BRIEF.md
# Multiplexed Address Request Phase Generator

This block starts a processor bus transaction by putting its request phase on a shared 36-bit address path. A requester offers an 8-byte-aligned physical address (bits 35..3), eight byte-enable bits and a read/write flag through a valid/ready handshake. The block then drives the request over two consecutive clocks. The first clock carries the whole address, a request strobe and two even-parity bits, one for each address field. The second clock reuses address lines 15..8 for the byte enables.

A receiver-side checker belongs to the same block and watches the address lines on its own port set. Whenever the strobe is seen, it recomputes both parity bits and pulses an error flag if either one disagrees. Address bits 35..32 extend the reachable space from 4 GB to 64 GB. Data transfer, arbitration and snooping are out of scope.

Top module: `addr_req_phase_gen`

## Requirements
- R1: While `rst_n` is low and after it is released, `req_ready` is 1, `bus_strb` is 0, `bus_addr` and `bus_par` are 0 and `par_err` is 0.
- R2: A request is accepted at a rising clock edge where `req_valid` and `req_ready` are both 1. In the next clock `bus_strb` is 1, `bus_addr[35:3]` equals the accepted address, `bus_addr[2:0]` is 0 and `bus_wr` equals the accepted flag (1 = write).
- R3: In the clock after the strobe, `bus_strb` is 0 and `bus_addr[15:8]` carries byte enables 7..0, with enable i on line 8+i. All other address lines are 0, `bus_par` is 0 and `bus_wr` still holds the flag.
- R4: During the strobe clock, `bus_par[0]` makes the count of ones over `bus_addr[23:3]` plus itself even.
- R5: During the strobe clock, `bus_par[1]` makes the count of ones over `bus_addr[35:24]` plus itself even.
- R6: `req_ready` is 0 in both clocks of a phase. Requests offered then, whatever their contents, have no effect on the phase. A request held valid is accepted in the first clock after the second phase clock, so back-to-back requests start every three clocks.
- R7: When `mon_strb` is 1 at a rising edge and either bit of `mon_par` differs from the even parity recomputed over the matching field of `mon_addr`, `par_err` is 1 for exactly the following clock.
- R8: `par_err` stays 0 when the sampled parity matches, and when `mon_strb` is 0 whatever `mon_par` holds.
- R9: Outside a request phase, `bus_addr`, `bus_par`, `bus_strb` and `bus_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 33 | Physical address bits 35..3 |
| req_be | input | 8 | Byte enables 7..0 |
| req_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | output | 36 | Shared address lines |
| bus_par | output | 2 | Address parity: bit 0 over 23..3, bit 1 over 35..24 |
| bus_strb | output | 1 | Request strobe, first phase clock |
| bus_wr | output | 1 | Direction of the transaction |
| mon_addr | input | 33 | Receiver view of address lines 35..3 |
| mon_par | input | 2 | Receiver view of parity lines |
| mon_strb | input | 1 | Receiver view of the strobe |
| par_err | output | 1 | One-clock parity mismatch pulse |

## Verification
The bench walks single ones across the boundary between bits 23 and 24. A design that placed the parity split one bit off would then report the wrong parity bit. It offers changing requests while a phase is in flight, and holds valid for back-to-back traffic: a block that accepts early would corrupt the byte-enable clock or lose a request. Parity is corrupted on each line separately, on both lines at once, and while no strobe is present. A checker that combined the bits, sampled at the wrong time or ignored the strobe would show a missing, extra or stretched error pulse. Reads and writes with assorted byte-enable patterns are checked so that a slip in the lane position on lines 15..8 shows up.

// File: rtl/arpg_pkg.sv
package arpg_pkg;
  localparam int unsigned ADDR_W    = 36;
  localparam int unsigned ALIGN_LO  = 3;
  localparam int unsigned BE_W      = 8;
  localparam int unsigned BE_LSB    = 8;
  localparam int unsigned PAR_SPLIT = 24;
  localparam int unsigned PAR_W     = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_BE   = 2'd2
  } phase_e;
endpackage

// File: rtl/arpg_addr_parity.sv
module arpg_addr_parity #(
  parameter int unsigned ADDR_W = 36,
  parameter int unsigned LO     = 3,
  parameter int unsigned SPLIT  = 24
) (
  input  logic [ADDR_W-1:LO] addr,
  output logic [1:0]         par
);
  localparam int unsigned LOW_N  = SPLIT - LO;
  localparam int unsigned HIGH_N = ADDR_W - SPLIT;

  logic [LOW_N-1:0]  low_field;
  logic [HIGH_N-1:0] high_field;

  always_comb begin
    low_field  = addr[SPLIT-1:LO];
    high_field = addr[ADDR_W-1:SPLIT];
    par[0]     = ^low_field;
    par[1]     = ^high_field;
  end
endmodule

// File: rtl/arpg_sequencer.sv
module arpg_sequencer
  import arpg_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned LO    = ALIGN_LO,
  parameter int unsigned BW    = BE_W,
  parameter int unsigned BLSB  = BE_LSB,
  parameter int unsigned SPLIT = PAR_SPLIT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:LO]  req_addr,
  input  logic [BW-1:0]   req_be,
  input  logic            req_wr,
  output logic [AW-1:0]   bus_addr,
  output logic [1:0]      bus_par,
  output logic            bus_strb,
  output logic            bus_wr
);
  localparam int unsigned PAD_W = AW - BW;

  phase_e          ph_q, ph_d;
  logic [AW-1:LO]  addr_q;
  logic [BW-1:0]   be_q;
  logic            wr_q;
  logic            take;
  logic [1:0]      par_calc;
  logic [AW-1:0]   be_lines;

  assign take = req_valid && (ph_q == PH_IDLE);

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (take) ph_d = PH_ADDR;
      PH_ADDR: ph_d = PH_BE;
      PH_BE:   ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
      wr_q   <= 1'b0;
    end else if (take) begin
      addr_q <= req_addr;
      be_q   <= req_be;
      wr_q   <= req_wr;
    end
  end

  arpg_addr_parity #(.ADDR_W(AW), .LO(LO), .SPLIT(SPLIT)) u_gen_par (
    .addr (addr_q),
    .par  (par_calc)
  );

  assign be_lines = {{PAD_W{1'b0}}, be_q} << BLSB;

  always_comb begin
    req_ready = (ph_q == PH_IDLE);
    bus_strb  = (ph_q == PH_ADDR);
    bus_wr    = (ph_q != PH_IDLE) && wr_q;
    bus_par   = '0;
    bus_addr  = '0;
    if (ph_q == PH_ADDR) begin
      bus_addr = {addr_q, {LO{1'b0}}};
      bus_par  = par_calc;
    end else if (ph_q == PH_BE) begin
      bus_addr = be_lines;
    end
  end

  AST_STRB_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strb |=> !bus_strb); // R2
  AST_ACCEPT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_strb && bus_addr[AW-1:LO] == $past(req_addr))); // R2
  AST_BE_ONLY_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strb |=> ((bus_addr & ~({{PAD_W{1'b0}}, {BW{1'b1}}} << BLSB)) == '0)); // R3
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strb |=> !req_ready); // R6
endmodule

// File: rtl/arpg_rx_check.sv
module arpg_rx_check
  import arpg_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned LO    = ALIGN_LO,
  parameter int unsigned SPLIT = PAR_SPLIT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:LO] mon_addr,
  input  logic [1:0]     mon_par,
  input  logic           mon_strb,
  output logic           par_err
);
  logic [1:0] par_exp;
  logic       err_d, err_q;

  arpg_addr_parity #(.ADDR_W(AW), .LO(LO), .SPLIT(SPLIT)) u_chk_par (
    .addr (mon_addr),
    .par  (par_exp)
  );

  assign err_d = mon_strb && (par_exp != mon_par);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign par_err = err_q;

  AST_ERR_NEEDS_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(mon_strb)); // R8
  AST_ERR_ON_BAD_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_strb && (mon_par != par_exp)) |=> par_err); // R7
endmodule

// File: rtl/addr_req_phase_gen.sv
module addr_req_phase_gen
  import arpg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:ALIGN_LO] req_addr,
  input  logic [BE_W-1:0]         req_be,
  input  logic                    req_wr,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [PAR_W-1:0]        bus_par,
  output logic                    bus_strb,
  output logic                    bus_wr,
  input  logic [ADDR_W-1:ALIGN_LO] mon_addr,
  input  logic [PAR_W-1:0]        mon_par,
  input  logic                    mon_strb,
  output logic                    par_err
);
  arpg_sequencer #(
    .AW(ADDR_W), .LO(ALIGN_LO), .BW(BE_W), .BLSB(BE_LSB), .SPLIT(PAR_SPLIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wr    (req_wr),
    .bus_addr  (bus_addr),
    .bus_par   (bus_par),
    .bus_strb  (bus_strb),
    .bus_wr    (bus_wr)
  );

  arpg_rx_check #(
    .AW(ADDR_W), .LO(ALIGN_LO), .SPLIT(PAR_SPLIT)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .mon_addr (mon_addr),
    .mon_par  (mon_par),
    .mon_strb (mon_strb),
    .par_err  (par_err)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_addr == '0 && bus_par == '0 && !bus_strb && !bus_wr)); // R9
endmodule

// File: tb/test_addr_req_phase_gen.sv
module test_addr_req_phase_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [35:3] req_addr = '0;
  logic [7:0]  req_be = '0;
  logic        req_wr = 1'b0;
  logic [35:0] bus_addr;
  logic [1:0]  bus_par;
  logic        bus_strb;
  logic        bus_wr;
  logic [1:0]  inj = 2'b00;
  logic [1:0]  mon_par;
  logic        par_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct packed {
    logic [35:3] a;
    logic [7:0]  be;
    logic        w;
  } item_t;
  item_t exp_q[$];
  item_t cur;
  bit    in_be = 0;
  bit    err_exp = 0;

  always #10 clk = ~clk;

  assign mon_par = bus_par ^ inj;

  addr_req_phase_gen i_addr_req_phase_gen (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_be(req_be), .req_wr(req_wr),
    .bus_addr(bus_addr), .bus_par(bus_par), .bus_strb(bus_strb), .bus_wr(bus_wr),
    .mon_addr(bus_addr[35:3]), .mon_par(mon_par), .mon_strb(bus_strb),
    .par_err(par_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] epar(input logic [35:3] a);
    return {^a[35:24], ^a[23:3]};
  endfunction

  // monitor: scoreboard pop on strobe, lane check in the following clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(par_err == err_exp, "R7/R8 par_err", 64'(par_err), 64'(err_exp));
      err_exp = 0;
      if (bus_strb) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected strobe", 64'(bus_addr), 64'd0);
        end else begin
          cur = exp_q.pop_front();
          chk(bus_addr == {cur.a, 3'b000}, "R2 address", 64'(bus_addr), 64'({cur.a, 3'b000}));
          chk(bus_wr == cur.w, "R2 write flag", 64'(bus_wr), 64'(cur.w));
          chk(bus_par[0] == epar(cur.a)[0], "R4 parity low", 64'(bus_par), 64'(epar(cur.a)));
          chk(bus_par[1] == epar(cur.a)[1], "R5 parity high", 64'(bus_par), 64'(epar(cur.a)));
          chk(!req_ready, "R6 busy in address clock", 64'(req_ready), 64'd0);
          err_exp = (inj != 2'b00);
          in_be = 1;
        end
      end else if (in_be) begin
        in_be = 0;
        chk(bus_addr == (36'(cur.be) << 8), "R3 byte lanes", 64'(bus_addr), 64'(36'(cur.be) << 8));
        chk(bus_par == 2'b00 && bus_wr == cur.w, "R3 parity/wr", 64'({bus_par, bus_wr}), 64'({2'b00, cur.w}));
        chk(!req_ready, "R6 busy in enable clock", 64'(req_ready), 64'd0);
      end else begin
        chk(bus_addr == '0 && bus_par == '0 && !bus_wr, "R9 idle quiet",
            64'({bus_par, bus_wr, bus_addr}), 64'd0);
        chk(req_ready, "R6 ready when idle", 64'(req_ready), 64'd1);
      end
    end
  end

  task automatic send(input logic [35:3] a, input logic [7:0] be, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_be = be; req_wr = w;
    while (!req_ready) @(negedge clk);
    exp_q.push_back('{a: a, be: be, w: w});
    @(posedge clk);
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(req_ready && !bus_strb && bus_addr == '0 && bus_par == '0 && !par_err,
        "R1 reset state", 64'({req_ready, bus_strb, par_err, bus_addr}), 64'h1_0000_0000_0 << 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_strb && bus_addr == '0, "R1 after release",
        64'({req_ready, bus_strb}), 64'h2);

    send('0, 8'hFF, 1'b0);
    go_idle(2);
    send('1, 8'h01, 1'b1);
    go_idle(2);
    // walking ones around the parity split (R4, R5)
    for (int b = 20; b < 28; b++) begin
      send(33'(1) << (b - 3), 8'(1) << (b % 8), b[0]);
    end
    go_idle(2);
    // varied patterns, back-to-back (R6)
    for (int k = 0; k < 12; k++) begin
      send({$urandom(), 1'b0} ^ {$urandom(), 1'b1}, 8'($urandom()), k[0]);
    end
    go_idle(2);
    // junk offered while a phase is in flight (R6)
    send(33'h1_2345_6789, 8'hA5, 1'b1);
    @(negedge clk);
    req_addr = 33'h0_DEAD_BEEF; req_be = 8'h3C; req_wr = 1'b0;
    chk(!req_ready, "R6 no accept in address clock", 64'(req_ready), 64'd0);
    @(negedge clk);
    req_addr = 33'h1_FFFF_0000; req_be = 8'hC3;
    chk(!req_ready, "R6 no accept in enable clock", 64'(req_ready), 64'd0);
    req_valid = 1'b0;
    go_idle(2);
    // parity corruption seen by the receiver (R7)
    for (int m = 1; m < 4; m++) begin
      @(negedge clk);
      inj = 2'(m);
      send(33'h0_8000_1234 + 33'(m), 8'h0F, 1'b0);
      go_idle(1);
      inj = 2'b00;
      go_idle(2);
    end
    // corrupted parity lines without strobe (R8)
    @(negedge clk);
    inj = 2'b11;
    repeat (4) @(negedge clk);
    inj = 2'b00;
    send(33'h1_0F0F_0F0F, 8'h80, 1'b1);
    go_idle(4);
    chk(exp_q.size() == 0, "R2 all requests issued", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule